// File: doc/BRIEF.md
# Status-Decoding Bus Command Controller

This block turns the three-bit cycle status reported by a processor into memory and I/O command strobes. While the status reads passive (`111`), the bus is idle. On the first clock edge where the status shows any other code, the controller starts a bus cycle and captures that code. For one clock it raises an address latch enable. From the next clock it drives the command strobe that matches the captured code, together with data enable and a transmit/receive direction. The cycle ends on the clock edge where the status reads passive again.

The captured code governs the whole cycle. Status changes between active codes inside a cycle are ignored. If the status goes passive during the address clock, the cycle is abandoned and no strobe is issued. A halt code produces the address pulse but no command.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: While reset is held, and after it until a cycle starts, all five strobes are high and `ale_o`, `den_o` and `dt_r_o` are low.
- R2: When the status is seen non-passive at an edge while idle, `ale_o` is high for exactly the following clock and is then low for the rest of the cycle.
- R3: A command strobe goes low in the clock after the `ale_o` clock. It stays low until the edge at which the status is seen as `111`, and it is high from that edge on.
- R4: The captured code selects the strobe: `000` selects `inta_n_o`, `001` selects `iord_n_o`, `010` selects `iowr_n_o`, `100` (code fetch) and `101` select `mrd_n_o`, and `110` selects `mwr_n_o`.
- R5: Code `011` (halt) produces the `ale_o` pulse. No strobe and no `den_o` follow it.
- R6: At most one strobe is low at any time.
- R7: `dt_r_o` is high during the address and command clocks of a cycle with code `010` or `110`. It is low at all other times.
- R8: `den_o` is high exactly while a command strobe is low, and it is never high together with `ale_o`.
- R9: If the status is seen as `111` at the edge that ends the `ale_o` clock, the cycle is abandoned and no strobe is issued.
- R10: A change from one active code to another within a cycle has no effect. The code captured at the start keeps driving the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stat_i | input | 3 | Cycle status from the processor, `111` = passive |
| ale_o | output | 1 | Address latch enable, one-clock pulse |
| den_o | output | 1 | Data enable, active high |
| dt_r_o | output | 1 | Direction: high = transmit (write), low = receive |
| mrd_n_o | output | 1 | Memory read command, active low |
| mwr_n_o | output | 1 | Memory write command, active low |
| iord_n_o | output | 1 | I/O read command, active low |
| iowr_n_o | output | 1 | I/O write command, active low |
| inta_n_o | output | 1 | Interrupt acknowledge command, active low |

## Verification
Every output comes from the sequencer's phase register and its captured code, so each result appears after the rising edge that samples the status. `ale_o` is due one edge after the status first turns active. The strobe, `den_o` and the write direction are due one edge later. Their release is due on the first edge that sees `111`. The bench applies the status at falling edges and advances its reference model on the same rising edges as the design. It compares the reference model against the outputs at every falling edge, so each expected value is checked in the clock where it is due.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int STAT_W = 3;
  localparam int NCMD   = 5;

  localparam int CMD_MRD  = 0;
  localparam int CMD_MWR  = 1;
  localparam int CMD_IORD = 2;
  localparam int CMD_IOWR = 3;
  localparam int CMD_INTA = 4;

  typedef enum logic [STAT_W-1:0] {
    ST_INTA = 3'b000,
    ST_IORD = 3'b001,
    ST_IOWR = 3'b010,
    ST_HALT = 3'b011,
    ST_CODE = 3'b100,
    ST_MRD  = 3'b101,
    ST_MWR  = 3'b110,
    ST_PASV = 3'b111
  } stat_e;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_CMD} phase_e;

  // one-hot command vector for a captured status code
  function automatic logic [NCMD-1:0] cmd_onehot(stat_e s);
    logic [NCMD-1:0] v;
    v = '0;
    case (s)
      ST_INTA:         v[CMD_INTA] = 1'b1;
      ST_IORD:         v[CMD_IORD] = 1'b1;
      ST_IOWR:         v[CMD_IOWR] = 1'b1;
      ST_CODE, ST_MRD: v[CMD_MRD]  = 1'b1;
      ST_MWR:          v[CMD_MWR]  = 1'b1;
      default:         v = '0;
    endcase
    return v;
  endfunction

  function automatic logic is_write(stat_e s);
    return (s == ST_IOWR) || (s == ST_MWR);
  endfunction
endpackage

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  output phase_e            phase_o,
  output stat_e             code_o,
  output logic              cyc_start_o,
  output logic              cyc_end_o
);
  phase_e phase_q;
  stat_e  code_q;
  logic   passive;

  assign passive     = (stat_i == ST_PASV);
  assign cyc_start_o = (phase_q == PH_IDLE) && !passive;
  assign cyc_end_o   = (phase_q != PH_IDLE) && passive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      code_q  <= ST_PASV;
    end else begin
      case (phase_q)
        PH_IDLE: if (cyc_start_o) begin
          phase_q <= PH_ADDR;
          code_q  <= stat_e'(stat_i);
        end
        PH_ADDR: phase_q <= passive ? PH_IDLE : PH_CMD;
        PH_CMD:  if (passive) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign code_o  = code_q;
endmodule

// File: rtl/bcc_strobe_dec.sv
module bcc_strobe_dec
  import bcc_pkg::*;
(
  input  phase_e          phase_i,
  input  stat_e           code_i,
  output logic [NCMD-1:0] strobe_n_o,
  output logic            ale_o,
  output logic            den_o,
  output logic            dt_r_o
);
  logic [NCMD-1:0] cmd_oh;

  assign cmd_oh = (phase_i == PH_CMD) ? cmd_onehot(code_i) : '0;

  for (genvar g = 0; g < NCMD; g++) begin : g_strobe
    assign strobe_n_o[g] = ~cmd_oh[g];
  end

  assign ale_o  = (phase_i == PH_ADDR);
  assign den_o  = |cmd_oh;
  assign dt_r_o = (phase_i != PH_IDLE) && is_write(code_i);
endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  output logic              ale_o,
  output logic              den_o,
  output logic              dt_r_o,
  output logic              mrd_n_o,
  output logic              mwr_n_o,
  output logic              iord_n_o,
  output logic              iowr_n_o,
  output logic              inta_n_o
);
  phase_e          phase;
  stat_e           code;
  logic            cyc_start;
  logic            cyc_end;
  logic [NCMD-1:0] strobe_n;

  bcc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_i     (stat_i),
    .phase_o    (phase),
    .code_o     (code),
    .cyc_start_o(cyc_start),
    .cyc_end_o  (cyc_end)
  );

  bcc_strobe_dec u_dec (
    .phase_i   (phase),
    .code_i    (code),
    .strobe_n_o(strobe_n),
    .ale_o     (ale_o),
    .den_o     (den_o),
    .dt_r_o    (dt_r_o)
  );

  assign mrd_n_o  = strobe_n[CMD_MRD];
  assign mwr_n_o  = strobe_n[CMD_MWR];
  assign iord_n_o = strobe_n[CMD_IORD];
  assign iowr_n_o = strobe_n[CMD_IOWR];
  assign inta_n_o = strobe_n[CMD_INTA];
endmodule

// File: rtl/bcc_chk.sv
module bcc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] stat_i,
  input logic       cyc_start,
  input logic       cyc_end,
  input logic       ale_o,
  input logic       den_o,
  input logic       dt_r_o,
  input logic       mrd_n_o,
  input logic       mwr_n_o,
  input logic       iord_n_o,
  input logic       iowr_n_o,
  input logic       inta_n_o
);
  logic [4:0] low;
  assign low = ~{inta_n_o, iowr_n_o, iord_n_o, mwr_n_o, mrd_n_o};

  // R2
  ale_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> ale_o);
  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o);
  // R3
  strobe_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((low != 5'b0) && !$past(low != 5'b0)) |-> $past(ale_o));
  // R3
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> (low == 5'b0) && !den_o);
  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(low));
  // R8
  den_no_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    den_o |-> !ale_o);
  // R7
  dir_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dt_r_o |-> (ale_o || !mwr_n_o || !iowr_n_o));
  // R9
  passive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_i == 3'b111 && !den_o) |=> (low == 5'b0));
endmodule

bind bus_cmd_ctrl bcc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stat_i   (stat_i),
  .cyc_start(cyc_start),
  .cyc_end  (cyc_end),
  .ale_o    (ale_o),
  .den_o    (den_o),
  .dt_r_o   (dt_r_o),
  .mrd_n_o  (mrd_n_o),
  .mwr_n_o  (mwr_n_o),
  .iord_n_o (iord_n_o),
  .iowr_n_o (iowr_n_o),
  .inta_n_o (inta_n_o)
);

// File: tb/tb_bus_cmd_ctrl.sv
module tb_bus_cmd_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] stat = 3'b111;
  logic ale, den, dtr, mrd_n, mwr_n, iord_n, iowr_n, inta_n;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .stat_i(stat),
    .ale_o(ale), .den_o(den), .dt_r_o(dtr),
    .mrd_n_o(mrd_n), .mwr_n_o(mwr_n), .iord_n_o(iord_n),
    .iowr_n_o(iowr_n), .inta_n_o(inta_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: age 0 idle, 1 address clock, 2 command clocks
  int age = 0;
  int mcode = 7;
  always @(posedge clk) begin
    if (!rst_n) begin
      age = 0; mcode = 7;
    end else if (age == 0) begin
      if (stat != 3'b111) begin age = 1; mcode = int'(stat); end
    end else if (stat == 3'b111) age = 0;
    else age = 2;
  end

  function automatic int want_low(int a, int c);
    if (a < 2) return 0;
    if (c == 0) return 5'b10000;
    if (c == 2) return 5'b01000;
    if (c == 1) return 5'b00100;
    if (c == 6) return 5'b00010;
    if (c == 4 || c == 5) return 5'b00001;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int lo, wl;
      lo = int'(~{inta_n, iowr_n, iord_n, mwr_n, mrd_n}) & 5'h1f;
      wl = want_low(age, mcode);
      chk(ale == (age == 1), "R2 ale", int'(ale), int'(age == 1));
      chk(lo == wl, "R4 strobes", lo, wl);
      chk((age >= 2) || lo == 0, "R3 strobe window", lo, 0);
      chk($countones(lo) <= 1, "R6 single strobe", lo, 0);
      chk(den == (wl != 0), "R8 den", int'(den), int'(wl != 0));
      chk(dtr == (age > 0 && (mcode == 2 || mcode == 6)), "R7 dir",
          int'(dtr), int'(age > 0 && (mcode == 2 || mcode == 6)));
    end
  end

  task automatic put(input logic [2:0] s, input int n);
    stat = s;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({inta_n, iowr_n, iord_n, mwr_n, mrd_n} == 5'h1f && !ale && !den && !dtr,
        "R1 reset", int'({ale, den, dtr}), 0);
    rst_n = 1'b1;
    put(3'b111, 2);
    chk({inta_n, iowr_n, iord_n, mwr_n, mrd_n} == 5'h1f && !ale,
        "R1 idle after reset", int'(ale), 0);
    for (int c = 0; c < 7; c++) begin
      put(3'(c), 4);
      put(3'b111, 2);
    end
    // R5 halt: address pulse then nothing
    put(3'b011, 1);
    chk(ale == 1'b1, "R5 halt ale", int'(ale), 1);
    put(3'b011, 3);
    chk({inta_n, iowr_n, iord_n, mwr_n, mrd_n} == 5'h1f && !den,
        "R5 halt no strobe", int'(den), 0);
    put(3'b111, 2);
    // R9 abort during address clock
    put(3'b101, 1);
    put(3'b111, 1);
    chk(mrd_n == 1'b1 && !den, "R9 abort", int'(mrd_n), 1);
    put(3'b111, 2);
    // R10 code change mid-cycle ignored
    put(3'b001, 2);
    put(3'b110, 3);
    chk(iord_n == 1'b0 && mwr_n == 1'b1 && !dtr, "R10 latched code",
        int'({iord_n, mwr_n, dtr}), 3'b010);
    put(3'b111, 2);
    // R3 long write cycle holds strobe
    put(3'b110, 40);
    chk(mwr_n == 1'b0 && dtr, "R3 long hold", int'(mwr_n), 0);
    put(3'b111, 1);
    chk(mwr_n == 1'b1, "R3 release", int'(mwr_n), 1);
    // back-to-back cycles with one passive clock
    put(3'b000, 3); put(3'b111, 1); put(3'b010, 3); put(3'b111, 3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule